// File: doc/BRIEF.md
# Atomic Reservation Memory Monitor

This block is a shared word-addressed memory that several requesters reach through one port each. Besides plain reads and writes it offers the two primitives that software locks are built from: a linked read paired with a conditional write, and an indivisible test-and-set. Each requester owns one reservation, which is a valid flag plus a word address. A linked read creates the reservation. The conditional write that follows commits only if no write has touched that word in the meantime. The requester gets back a 1 or a 0 in place of the data it offered.

Only one request is served per clock. A fixed-priority arbiter picks the lowest-numbered active requester. That request's read, its write and its reservation update all happen in the same cycle, so no other access can fall between the read and the write of an atomic operation. A requester keeps its request asserted until it sees its response pulse. Operation codes on `req_op` are: 0 plain read, 1 plain write, 2 linked read, 3 conditional write, 4 test-and-set. Codes 5 to 7 behave as a plain read.

Top module: `atomic_monitor`

## Requirements
- R1: After reset every response-valid bit is 0, every memory word reads 0 and no requester holds a reservation, so a conditional write issued first returns 0.
- R2: Among the requesters with `req_valid` high, the lowest index is served. Exactly that requester's `rsp_valid` bit pulses high for one cycle, in the cycle after its request is sampled, and at most one bit is high at a time.
- R3: A plain read (code 0) returns the stored word. A plain write (code 1) stores `req_wdata` and returns 0.
- R4: A linked read (code 2) returns the stored word and sets the requester's reservation to that address, replacing any reservation it held before.
- R5: A conditional write (code 3) whose requester holds a valid reservation for the same address stores the data and returns 1.
- R6: A conditional write with no valid reservation, or with a reservation for a different address, returns 0 and leaves memory unchanged.
- R7: A conditional write always clears its own requester's reservation, whether it succeeds or fails.
- R8: Any write to a reserved address clears that reservation for every requester. This covers plain writes (including the holder's own), successful conditional writes and test-and-set.
- R9: Test-and-set (code 4) writes 1 to the word in the same cycle it reads it. It returns 1 if the old value was 0 and returns 0 if the old value was nonzero.
- R10: Writes to other addresses and reads of any kind leave a reservation intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_REQ | Request active, one bit per requester, held until served |
| req_op | input | N_REQ*3 | Operation code per requester, 3 bits each |
| req_addr | input | N_REQ*ADDR_W | Word address per requester |
| req_wdata | input | N_REQ*DATA_W | Write data per requester |
| rsp_valid | output | N_REQ | One-cycle response pulse for the served requester |
| rsp_data | output | DATA_W | Read data or 1/0 result code of the served request |

## Verification
The hardest case to reach is an interleaving: one requester holds a reservation while another writes the same word between the linked read and the conditional write. A variant of this is two test-and-set requests to one lock word arriving in the same cycle. Directed sequences set up these interleavings explicitly. They include the holder breaking its own reservation, a linked read being replaced, and a write to a neighbouring address that must not disturb the reservation. A later phase issues a long run of requests from all requesters on only four addresses, so that collisions and stale reservations occur often. A cycle-level model in the bench tracks the expected result of every one of these requests.

// File: rtl/amon_pkg.sv
// Shared operation encoding for the atomic reservation memory monitor.
// Assumes a 3-bit operation field per requester.
package amon_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_LINK  = 3'd2,
        OP_COND  = 3'd3,
        OP_TAS   = 3'd4
    } amon_op_e;
endpackage

// File: rtl/amon_arbiter.sv
// Fixed-priority arbiter: grants the lowest-indexed active request.
// Assumes requesters hold their request until granted; output is combinational.
module amon_arbiter #(
    parameter int N_REQ = 3
) (
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt,
    output logic             any_gnt
);
    // Purpose: scan from index 0 upward and grant the first active request.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
        any_gnt = found;
    end
endmodule

// File: rtl/amon_store.sv
// Word-addressed storage array with a combinational read port and one
// synchronous write port. Assumes every word resets to zero.
module amon_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Purpose: clear every word on reset, otherwise commit the selected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Purpose: read the addressed word for the request served this cycle.
    assign rd_data = words[rd_addr];
endmodule

// File: rtl/amon_resv_table.sv
// One reservation (valid flag plus address) per requester. A linked read sets
// the reservation, a conditional write clears it, and any write to a matching
// address clears it for all requesters. Assumes one served request per cycle.
module amon_resv_table
    import amon_pkg::*;
#(
    parameter int N_REQ  = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  gnt,
    input  amon_op_e          op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic              hold_ok,
    output logic [N_REQ-1:0]  resv_valid
);
    logic [ADDR_W-1:0] resv_addr [N_REQ];
    logic [N_REQ-1:0]  match;

    for (genvar g = 0; g < N_REQ; g++) begin : g_slot
        // Purpose: update this requester's reservation from the served request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                resv_valid[g] <= 1'b0;
                resv_addr[g]  <= '0;
            end else if (gnt[g] && op == OP_LINK) begin
                resv_valid[g] <= 1'b1;
                resv_addr[g]  <= addr;
            end else if (gnt[g] && op == OP_COND) begin
                resv_valid[g] <= 1'b0;
            end else if (wr_en && resv_addr[g] == addr) begin
                resv_valid[g] <= 1'b0;
            end
        end

        // Purpose: flag a served requester whose live reservation covers addr.
        assign match[g] = gnt[g] && resv_valid[g] && (resv_addr[g] == addr);
    end

    assign hold_ok = |match;
endmodule

// File: rtl/atomic_monitor.sv
// Top of the atomic reservation memory monitor. It selects one request per
// cycle, performs its read, write and reservation update together, and
// registers a one-cycle response. Assumes requests stay asserted until served.
module atomic_monitor
    import amon_pkg::*;
#(
    parameter int N_REQ  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REQ-1:0]         req_valid,
    input  logic [N_REQ*OP_W-1:0]    req_op,
    input  logic [N_REQ*ADDR_W-1:0]  req_addr,
    input  logic [N_REQ*DATA_W-1:0]  req_wdata,
    output logic [N_REQ-1:0]         rsp_valid,
    output logic [DATA_W-1:0]        rsp_data
);
    logic [N_REQ-1:0]  gnt;
    logic              any_gnt;
    logic [OP_W-1:0]   sel_op_raw;
    amon_op_e          sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              hold_ok;
    logic [N_REQ-1:0]  resv_valid;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] result;

    amon_arbiter #(.N_REQ(N_REQ)) u_arb (
        .req     (req_valid),
        .gnt     (gnt),
        .any_gnt (any_gnt)
    );

    // Purpose: route the granted requester's fields onto the shared datapath.
    always_comb begin
        sel_op_raw = '0;
        sel_addr   = '0;
        sel_wdata  = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (gnt[i]) begin
                sel_op_raw = req_op[i*OP_W +: OP_W];
                sel_addr   = req_addr[i*ADDR_W +: ADDR_W];
                sel_wdata  = req_wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    // Purpose: fold unused operation codes onto a plain read.
    always_comb begin
        case (sel_op_raw)
            3'd1:    sel_op = OP_WRITE;
            3'd2:    sel_op = OP_LINK;
            3'd3:    sel_op = OP_COND;
            3'd4:    sel_op = OP_TAS;
            default: sel_op = OP_READ;
        endcase
    end

    amon_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (sel_addr),
        .rd_data (mem_rdata),
        .wr_en   (wr_en),
        .wr_addr (sel_addr),
        .wr_data (wr_data)
    );

    amon_resv_table #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt        (gnt),
        .op         (sel_op),
        .addr       (sel_addr),
        .wr_en      (wr_en),
        .hold_ok    (hold_ok),
        .resv_valid (resv_valid)
    );

    // Purpose: decide whether the served request writes, what it writes and what it returns.
    always_comb begin
        wr_en   = 1'b0;
        wr_data = sel_wdata;
        result  = mem_rdata;
        case (sel_op)
            OP_WRITE: begin
                wr_en  = any_gnt;
                result = '0;
            end
            OP_COND: begin
                wr_en  = any_gnt && hold_ok;
                result = DATA_W'(hold_ok);
            end
            OP_TAS: begin
                wr_en   = any_gnt;
                wr_data = DATA_W'(1);
                result  = DATA_W'(mem_rdata == '0);
            end
            default: ;
        endcase
    end

    // Purpose: register the one-cycle response pulse and its data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= gnt;
            rsp_data  <= any_gnt ? result : '0;
        end
    end
endmodule

// File: rtl/amon_checker.sv
// Protocol and reservation checks for atomic_monitor, bound to every instance.
// Assumes the grant vector, selected op code and reservation flags are visible.
module amon_checker #(
    parameter int N_REQ = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req_valid,
    input logic [N_REQ-1:0] rsp_valid,
    input logic [N_REQ-1:0] gnt,
    input logic [2:0]       sel_op,
    input logic [N_REQ-1:0] resv_valid
);
    // R2: never more than one response at a time
    a_r2_single_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    // R2: any active request leads to a response in the next cycle
    a_r2_no_idle_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |=> (|rsp_valid));

    // R2: requester 0 always wins
    a_r2_top_priority: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |=> rsp_valid[0]);

    for (genvar g = 0; g < N_REQ; g++) begin : g_chk
        // R2: a response only answers a request seen in the previous cycle
        a_r2_rsp_has_req: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[g] |-> $past(req_valid[g]));

        // R4: a served linked read leaves a live reservation
        a_r4_link_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[g] && sel_op == 3'd2) |=> resv_valid[g]);

        // R7: a served conditional write leaves no reservation
        a_r7_cond_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[g] && sel_op == 3'd3) |=> !resv_valid[g]);
    end
endmodule

bind atomic_monitor amon_checker #(.N_REQ(N_REQ)) u_amon_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .gnt        (gnt),
    .sel_op     (sel_op),
    .resv_valid (resv_valid)
);

// File: tb/tb_atomic_monitor.sv
// Bench for atomic_monitor: a behavioural reference model predicts the
// response of every cycle and compares it at the falling edge.
module tb_atomic_monitor;
    localparam int N  = 3;
    localparam int AW = 4;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*3-1:0]  req_op = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0]    rsp_valid;
    logic [DW-1:0]   rsp_data;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // bench-side request slots
    bit          bv [N];
    logic [2:0]  bop[N];
    logic [AW-1:0] bad[N];
    logic [DW-1:0] bdt[N];

    // reference model state
    logic [DW-1:0] m_mem [1<<AW];
    bit            m_rv  [N];
    logic [AW-1:0] m_ra  [N];

    always #10 clk = ~clk;

    atomic_monitor #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        m_mem[a] = d;
        for (int j = 0; j < N; j++) if (m_ra[j] == a) m_rv[j] = 0;
    endtask

    // one clock: drive at the falling edge, predict, compare at the next falling edge
    task automatic step(input string tag);
        int g = -1;
        logic [N-1:0]  em = '0;
        logic [DW-1:0] ed = '0;
        for (int i = 0; i < N; i++) begin
            req_valid[i]           = bv[i];
            req_op[i*3 +: 3]       = bop[i];
            req_addr[i*AW +: AW]   = bad[i];
            req_wdata[i*DW +: DW]  = bdt[i];
            if (bv[i] && g < 0) g = i;
        end
        if (g >= 0) begin
            em[g] = 1'b1;
            case (bop[g])
                3'd1: begin ed = '0; model_write(bad[g], bdt[g]); end
                3'd2: begin ed = m_mem[bad[g]]; m_rv[g] = 1; m_ra[g] = bad[g]; end
                3'd3: begin
                    bit ok = m_rv[g] && (m_ra[g] == bad[g]);
                    m_rv[g] = 0;
                    ed = DW'(ok);
                    if (ok) model_write(bad[g], bdt[g]);
                end
                3'd4: begin
                    ed = DW'(m_mem[bad[g]] == '0);
                    model_write(bad[g], DW'(1));
                end
                default: ed = m_mem[bad[g]];
            endcase
        end
        @(negedge clk);
        check({tag, " valid"}, DW'(rsp_valid), DW'(em));
        if (g >= 0) begin
            check({tag, " data"}, rsp_data, ed);
            bv[g] = 0;
        end
    endtask

    task automatic put(input int r, input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bv[r] = 1; bop[r] = op; bad[r] = a; bdt[r] = d;
    endtask

    task automatic one(input string tag, input int r, input logic [2:0] op,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        put(r, op, a, d);
        step(tag);
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
        for (int i = 0; i < N; i++) begin
            m_rv[i] = 0; m_ra[i] = '0; bv[i] = 0; bop[i] = '0; bad[i] = '0; bdt[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", DW'(rsp_valid), '0);
        rst_n = 1'b1;

        // R1: empty reservations and zeroed memory after reset
        one("R1 cond after reset", 0, 3'd3, 4'd3, 16'h00aa);
        one("R1 read after reset", 1, 3'd0, 4'd3, '0);
        // R3: plain write then read by another requester
        one("R3 write", 0, 3'd1, 4'd5, 16'h1234);
        one("R3 read", 1, 3'd0, 4'd5, '0);
        // R4/R5: linked read then successful conditional write
        one("R4 link", 1, 3'd2, 4'd5, '0);
        one("R5 cond ok", 1, 3'd3, 4'd5, 16'h0055);
        one("R5 read back", 2, 3'd0, 4'd5, '0);
        // R7: second conditional write without a new link fails
        one("R7 cond again", 1, 3'd3, 4'd5, 16'h0066);
        // R7: failed conditional write also consumes the reservation
        one("R7 link", 0, 3'd2, 4'd4, '0);
        one("R7 cond wrong addr", 0, 3'd3, 4'd6, 16'h0077);
        one("R7 cond after fail", 0, 3'd3, 4'd4, 16'h0088);
        // R6: mismatched address fails and leaves memory unchanged
        one("R6 link", 0, 3'd2, 4'd2, '0);
        one("R6 cond other addr", 0, 3'd3, 4'd6, 16'hbeef);
        one("R6 read unchanged", 0, 3'd0, 4'd6, '0);
        // R8: another requester's write breaks both reservations
        one("R8 link a", 0, 3'd2, 4'd7, '0);
        one("R8 link b", 1, 3'd2, 4'd7, '0);
        one("R8 store", 2, 3'd1, 4'd7, 16'h0101);
        one("R8 cond a", 0, 3'd3, 4'd7, 16'h0202);
        one("R8 cond b", 1, 3'd3, 4'd7, 16'h0303);
        // R8: holder's own plain write breaks its reservation
        one("R8 own link", 2, 3'd2, 4'd8, '0);
        one("R8 own store", 2, 3'd1, 4'd8, 16'h0404);
        one("R8 own cond", 2, 3'd3, 4'd8, 16'h0505);
        // R8: a successful conditional write breaks a peer's reservation
        one("R8 link p", 0, 3'd2, 4'd9, '0);
        one("R8 link q", 1, 3'd2, 4'd9, '0);
        one("R8 cond p", 0, 3'd3, 4'd9, 16'h0606);
        one("R8 cond q", 1, 3'd3, 4'd9, 16'h0707);
        // R10: writes elsewhere and reads do not disturb a reservation
        one("R10 link", 0, 3'd2, 4'd10, '0);
        one("R10 store other", 1, 3'd1, 4'd11, 16'h0808);
        one("R10 read same", 2, 3'd0, 4'd10, '0);
        one("R10 cond", 0, 3'd3, 4'd10, 16'h0909);
        // R4: a new link replaces the old reservation
        one("R4 link first", 0, 3'd2, 4'd1, '0);
        one("R4 link second", 0, 3'd2, 4'd2, '0);
        one("R4 cond old", 0, 3'd3, 4'd1, 16'h0a0a);
        // R9: test-and-set on a free and then a held lock word
        one("R9 tas free", 0, 3'd4, 4'd12, '0);
        one("R9 read held", 1, 3'd0, 4'd12, '0);
        one("R9 tas held", 1, 3'd4, 4'd12, '0);
        one("R9 release", 0, 3'd1, 4'd12, '0);
        one("R9 tas again", 1, 3'd4, 4'd12, '0);
        // R8: test-and-set breaks a reservation on the lock word
        one("R8 link lock", 2, 3'd2, 4'd13, '0);
        one("R8 tas lock", 0, 3'd4, 4'd13, '0);
        one("R8 cond lock", 2, 3'd3, 4'd13, 16'h0000);
        // R2/R9: contending test-and-set in one cycle
        put(0, 3'd4, 4'd14, '0);
        put(1, 3'd4, 4'd14, '0);
        step("R2 contention first");
        step("R2 contention second");
        // R2: all three at once are served in index order
        put(0, 3'd0, 4'd5, '0);
        put(1, 3'd1, 4'd5, 16'hcafe);
        put(2, 3'd0, 4'd5, '0);
        step("R2 order 0");
        step("R2 order 1");
        step("R2 order 2");
        step("R2 idle");

        // mixed traffic on four addresses
        for (int k = 0; k < 600; k++) begin
            for (int i = 0; i < N; i++) begin
                if (!bv[i] && ($urandom % 3 != 0)) begin
                    int o = $urandom % 8;
                    put(i, (o > 4) ? 3'(o - 4) : 3'(o), AW'($urandom % 4), DW'($urandom));
                end
            end
            step("R2 mixed");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule